// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer and Gating

This block sits between the frequency synthesizer of a clock generator and its output drivers. It turns an asynchronous, active-low power-down pin into an ordered shutdown. The pin is first synchronized into the internal CPU clock domain. Every output gate is then closed on a falling edge of that clock, and the block waits until the slow reference output has parked low. Only after that does it drop the enables for the VCO and the crystal oscillator.

When the pin is released, the VCO and oscillator enables come back at once. All outputs stay gated low for a start-up window of `CLK_KHZ * STARTUP_US / 1000` cycles, so the outputs see nothing while the oscillator restarts. The default window is 3 ms at 133 MHz.

During normal running, each clock group (CPU, SDRAM, PCI, 66 MHz, 48 MHz, APIC) is gated by a per-output enable mask. A mask bit of 1 lets that output run and a mask bit of 0 holds it low. The free-running SDRAM feedback clock is not masked.

Top module: `clk_pd_gate_ctrl`

## Requirements
- R1: `pdReqN` passes through two rising-edge flip-flops before it has any effect, so gate outputs are unchanged at the third rising edge after the pin falls.
- R2: Once the synchronized request is seen at a rising edge, every group gate and the free-running gate go low on the following falling edge.
- R3: `vcoEn` and `oscEn` fall only when all gates, including `refGate`, are low. They stay high for as long as `refLevel` is high.
- R4: `refGate` changes only on a falling edge at which `refLevel` is low.
- R5: While the synchronized pin stays low after shutdown, `vcoEn`/`oscEn` stay low and all gates stay low, whatever the masks do.
- R6: After the pin rises, `vcoEn` and `oscEn` return high at the third rising edge. All gates stay low until `CLK_KHZ*STARTUP_US/1000` more rising edges have passed, and they open on the falling edge after that.
- R7: In normal running, each bit of `cpuGate`, `sdrGate`, `pciGate`, `v66Gate`, `usbGate` and `apicGate` equals the matching mask bit (1 = run, 0 = held low). A mask change shows on the next falling edge.
- R8: In normal running, `sdrFreeGate` is 1 regardless of `sdrEn`.
- R9: During reset, all gates are 0 and `vcoEn`/`oscEn` are 1. After release, the gates follow the masks from the first falling edge.
- R10: A new power-down request during the start-up window returns to shutdown without any gate opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReqN | input | 1 | Asynchronous active-low power-down pin |
| refLevel | input | 1 | Present level of the reference clock |
| cpuEn | input | N_CPU | CPU output enable mask |
| sdrEn | input | N_SDR | SDRAM output enable mask |
| pciEn | input | N_PCI | PCI output enable mask |
| v66En | input | N_V66 | 66 MHz output enable mask |
| usbEn | input | N_USB | 48 MHz output enable mask |
| apicEn | input | N_APIC | APIC output enable mask |
| cpuGate | output | N_CPU | CPU output gates |
| sdrGate | output | N_SDR | SDRAM output gates |
| sdrFreeGate | output | 1 | Free-running SDRAM feedback gate |
| pciGate | output | N_PCI | PCI output gates |
| v66Gate | output | N_V66 | 66 MHz output gates |
| usbGate | output | N_USB | 48 MHz output gates |
| apicGate | output | N_APIC | APIC output gates |
| refGate | output | 1 | Reference output gate |
| vcoEn | output | 1 | VCO enable |
| oscEn | output | 1 | Crystal oscillator enable |

## Verification
Two things can fall in the same cycle: a mask update and the falling edge on which power-down closes the gates. The bench changes masks with random values just after the pin drops and during shutdown, and it expects zeros, not the new masks. Two more collisions are provoked on purpose. In one, the reference is high when the gates close; the bench expects `refGate` to stay open and the oscillator to stay enabled until the level falls. In the other, a fresh request arrives inside the start-up window; the bench expects the enables to drop again with every gate held closed.

// File: rtl/clk_pd_gate_pkg.sv
package clk_pd_gate_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_GATE, ST_REFWAIT, ST_OFF, ST_WAKE
  } seqState_t;

  typedef struct packed {
    logic allowRun;  // gates may follow their masks
    logic oscOn;     // VCO and oscillator enabled
  } seqCtl_t;
endpackage

// File: rtl/clk_pd_gate_seq.sv
module clk_pd_gate_seq
  import clk_pd_gate_pkg::*;
#(
  parameter int STARTUP_CYCLES = 399000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pdReqN,
  input  logic    refParked,
  output seqCtl_t ctl
);
  localparam int CW = $clog2(STARTUP_CYCLES + 1);

  logic      syncA, syncB;
  seqState_t state;
  logic [CW-1:0] wakeCnt;

  // two-stage synchronizer, output high = power-down requested
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= ~pdReqN;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wakeCnt <= '0;
    end else begin
      unique case (state)
        ST_RUN:     if (syncB) state <= ST_GATE;
        ST_GATE:    state <= ST_REFWAIT;
        ST_REFWAIT: if (refParked) state <= ST_OFF;
        ST_OFF: begin
          wakeCnt <= '0;
          if (!syncB) state <= ST_WAKE;
        end
        ST_WAKE: begin
          if (syncB) state <= ST_OFF;
          else if (wakeCnt == CW'(STARTUP_CYCLES - 1)) state <= ST_RUN;
          else wakeCnt <= wakeCnt + 1'b1;
        end
        default:    state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    ctl.allowRun = (state == ST_RUN);
    ctl.oscOn    = (state != ST_OFF);
  end
endmodule

// File: rtl/clk_pd_gate_dp.sv
module clk_pd_gate_dp
  import clk_pd_gate_pkg::*;
#(
  parameter int N_CPU = 2, N_SDR = 8, N_PCI = 8, N_V66 = 2, N_USB = 3, N_APIC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              refLevel,
  input  logic [N_CPU-1:0]  cpuEn,
  input  logic [N_SDR-1:0]  sdrEn,
  input  logic [N_PCI-1:0]  pciEn,
  input  logic [N_V66-1:0]  v66En,
  input  logic [N_USB-1:0]  usbEn,
  input  logic [N_APIC-1:0] apicEn,
  output logic [N_CPU-1:0]  cpuGate,
  output logic [N_SDR-1:0]  sdrGate,
  output logic              sdrFreeGate,
  output logic [N_PCI-1:0]  pciGate,
  output logic [N_V66-1:0]  v66Gate,
  output logic [N_USB-1:0]  usbGate,
  output logic [N_APIC-1:0] apicGate,
  output logic              refGate,
  output logic              refParked
);
  localparam int NG = N_CPU + N_SDR + N_PCI + N_V66 + N_USB + N_APIC;

  logic [NG-1:0] maskAll, gateAll;
  assign maskAll = {cpuEn, sdrEn, pciEn, v66En, usbEn, apicEn};

  // one falling-edge flop per output, updated while the CPU-domain clocks are low
  for (genvar g = 0; g < NG; g++) begin : g_gate
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) gateAll[g] <= 1'b0;
      else       gateAll[g] <= ctl.allowRun & maskAll[g];
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sdrFreeGate <= 1'b0;
    else       sdrFreeGate <= ctl.allowRun;
  end

  // reference gate moves only while the reference itself sits low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)         refGate <= 1'b0;
    else if (!refLevel) refGate <= ctl.allowRun;
  end

  assign {cpuGate, sdrGate, pciGate, v66Gate, usbGate, apicGate} = gateAll;
  assign refParked = ~refGate & ~sdrFreeGate & ~(|gateAll);
endmodule

// File: rtl/clk_pd_gate_ctrl.sv
module clk_pd_gate_ctrl
  import clk_pd_gate_pkg::*;
#(
  parameter int N_CPU = 2, N_SDR = 8, N_PCI = 8, N_V66 = 2, N_USB = 3, N_APIC = 1,
  parameter int CLK_KHZ = 133000,
  parameter int STARTUP_US = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdReqN,
  input  logic              refLevel,
  input  logic [N_CPU-1:0]  cpuEn,
  input  logic [N_SDR-1:0]  sdrEn,
  input  logic [N_PCI-1:0]  pciEn,
  input  logic [N_V66-1:0]  v66En,
  input  logic [N_USB-1:0]  usbEn,
  input  logic [N_APIC-1:0] apicEn,
  output logic [N_CPU-1:0]  cpuGate,
  output logic [N_SDR-1:0]  sdrGate,
  output logic              sdrFreeGate,
  output logic [N_PCI-1:0]  pciGate,
  output logic [N_V66-1:0]  v66Gate,
  output logic [N_USB-1:0]  usbGate,
  output logic [N_APIC-1:0] apicGate,
  output logic              refGate,
  output logic              vcoEn,
  output logic              oscEn
);
  localparam int STARTUP_CYCLES = (CLK_KHZ * STARTUP_US) / 1000;

  seqCtl_t ctl;
  logic    refParked;

  clk_pd_gate_seq #(.STARTUP_CYCLES(STARTUP_CYCLES)) seq_i (
    .clk(clk), .rstN(rstN), .pdReqN(pdReqN), .refParked(refParked), .ctl(ctl)
  );

  clk_pd_gate_dp #(
    .N_CPU(N_CPU), .N_SDR(N_SDR), .N_PCI(N_PCI),
    .N_V66(N_V66), .N_USB(N_USB), .N_APIC(N_APIC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refLevel(refLevel),
    .cpuEn(cpuEn), .sdrEn(sdrEn), .pciEn(pciEn), .v66En(v66En),
    .usbEn(usbEn), .apicEn(apicEn),
    .cpuGate(cpuGate), .sdrGate(sdrGate), .sdrFreeGate(sdrFreeGate),
    .pciGate(pciGate), .v66Gate(v66Gate), .usbGate(usbGate),
    .apicGate(apicGate), .refGate(refGate), .refParked(refParked)
  );

  assign vcoEn = ctl.oscOn;
  assign oscEn = ctl.oscOn;
endmodule

// File: rtl/clk_pd_gate_chk.sv
module clk_pd_gate_chk #(
  parameter int N_CPU = 2, N_SDR = 8, N_PCI = 8, N_V66 = 2, N_USB = 3, N_APIC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              refLevel,
  input logic [N_CPU-1:0]  cpuGate,
  input logic [N_SDR-1:0]  sdrGate,
  input logic              sdrFreeGate,
  input logic [N_PCI-1:0]  pciGate,
  input logic [N_V66-1:0]  v66Gate,
  input logic [N_USB-1:0]  usbGate,
  input logic [N_APIC-1:0] apicGate,
  input logic              refGate,
  input logic              vcoEn,
  input logic              oscEn
);
  logic anyGate;
  assign anyGate = (|cpuGate) | (|sdrGate) | sdrFreeGate | (|pciGate) |
                   (|v66Gate) | (|usbGate) | (|apicGate) | refGate;

  // R3: oscillator shutdown only with every output parked low
  a_r3_off_after_park: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vcoEn) |-> !anyGate);

  // R3: crystal enable never drops while some output still runs
  a_r3_osc_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> !anyGate);

  // R4: reference gate moves only while the reference is low
  a_r4_ref_change_low: assert property (@(negedge clk) disable iff (!rstN)
    (refGate != $past(refGate)) |-> !$past(refLevel));

  // R6: right after restart the outputs are still held low
  a_r6_hold_after_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vcoEn) |=> !anyGate);

  // R8: any running CPU output implies the free-running clock is on
  a_r8_free_running: assert property (@(posedge clk) disable iff (!rstN)
    (|cpuGate) |-> sdrFreeGate);
endmodule

bind clk_pd_gate_ctrl clk_pd_gate_chk #(
  .N_CPU(N_CPU), .N_SDR(N_SDR), .N_PCI(N_PCI),
  .N_V66(N_V66), .N_USB(N_USB), .N_APIC(N_APIC)
) chk_i (
  .clk(clk), .rstN(rstN), .refLevel(refLevel),
  .cpuGate(cpuGate), .sdrGate(sdrGate), .sdrFreeGate(sdrFreeGate),
  .pciGate(pciGate), .v66Gate(v66Gate), .usbGate(usbGate),
  .apicGate(apicGate), .refGate(refGate), .vcoEn(vcoEn), .oscEn(oscEn)
);

// File: tb/clk_pd_gate_ctrl_tb_top.sv
module clk_pd_gate_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int N_CPU = 2, N_SDR = 8, N_PCI = 8, N_V66 = 2, N_USB = 3, N_APIC = 1;
  localparam int CLK_KHZ = 10, STARTUP_US = 2000;
  localparam int WAKE = CLK_KHZ * STARTUP_US / 1000;  // 20 cycles
  localparam int GW = N_CPU + N_SDR + 1 + N_PCI + N_V66 + N_USB + N_APIC + 1;

  logic clk = 1'b0, rstN = 1'b0, pdReqN = 1'b1, refLevel = 1'b0;
  logic [N_CPU-1:0]  cpuEn;
  logic [N_SDR-1:0]  sdrEn;
  logic [N_PCI-1:0]  pciEn;
  logic [N_V66-1:0]  v66En;
  logic [N_USB-1:0]  usbEn;
  logic [N_APIC-1:0] apicEn;
  logic [N_CPU-1:0]  cpuGate;
  logic [N_SDR-1:0]  sdrGate;
  logic              sdrFreeGate;
  logic [N_PCI-1:0]  pciGate;
  logic [N_V66-1:0]  v66Gate;
  logic [N_USB-1:0]  usbGate;
  logic [N_APIC-1:0] apicGate;
  logic              refGate, vcoEn, oscEn;

  int  nChk = 0, nBad = 0;
  bit  done = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_pd_gate_ctrl #(
    .N_CPU(N_CPU), .N_SDR(N_SDR), .N_PCI(N_PCI), .N_V66(N_V66),
    .N_USB(N_USB), .N_APIC(N_APIC), .CLK_KHZ(CLK_KHZ), .STARTUP_US(STARTUP_US)
  ) dut_i (.*);

  function automatic logic [GW-1:0] expGates(input bit run, input bit refOn);
    if (run) return {cpuEn, sdrEn, 1'b1, pciEn, v66En, usbEn, apicEn, refOn};
    return {{(GW-1){1'b0}}, refOn};
  endfunction

  function automatic logic [GW-1:0] actGates();
    return {cpuGate, sdrGate, sdrFreeGate, pciGate, v66Gate, usbGate, apicGate, refGate};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic randMasks();
    cpuEn  = N_CPU'($urandom);
    sdrEn  = N_SDR'($urandom);
    pciEn  = N_PCI'($urandom);
    v66En  = N_V66'($urandom);
    usbEn  = N_USB'($urandom);
    apicEn = N_APIC'($urandom);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    cpuEn = '1; sdrEn = '1; pciEn = '1; v66En = '1; usbEn = '1; apicEn = '1;
    tick(); tick();
    chk("R9 reset gates", 64'(actGates()), 64'(0));
    chk("R9 reset enables", {62'b0, vcoEn, oscEn}, 64'd3);
    rstN = 1'b1;
    tick();
    chk("R9 gates after release", 64'(actGates()), 64'(expGates(1, 1)));

    // R7 / R8: random masks while running
    for (int i = 0; i < 40; i++) begin
      randMasks();
      if (i % 5 == 0) sdrEn = '0;
      tick();
      chk("R7 masks", 64'(actGates()), 64'(expGates(1, 1)));
      chk("R8 free clock", 64'(sdrFreeGate), 64'd1);
    end

    // power-down with reference already low; masks change at the same time
    pdReqN = 1'b0;
    tick(); chk("R1 stage1", 64'(actGates()), 64'(expGates(1, 1)));
    randMasks();
    tick(); chk("R1 stage2", 64'(actGates()), 64'(expGates(1, 1)));
    tick(); chk("R1 edge3", 64'(actGates()), 64'(expGates(1, 1)));
    randMasks();
    tick(); chk("R2 gates closed", 64'(actGates()), 64'(0));
    chk("R3 osc still on", {62'b0, vcoEn, oscEn}, 64'd3);
    tick(); chk("R3 osc off", {62'b0, vcoEn, oscEn}, 64'd0);
    for (int i = 0; i < 10; i++) begin
      randMasks();
      tick();
      chk("R5 held off", {62'b0, vcoEn, oscEn}, 64'd0);
      chk("R5 gates low", 64'(actGates()), 64'(0));
    end

    // release and start-up window
    pdReqN = 1'b1;
    tick(); tick();
    chk("R6 still off", {62'b0, vcoEn, oscEn}, 64'd0);
    tick();
    chk("R6 osc back", {62'b0, vcoEn, oscEn}, 64'd3);
    for (int i = 1; i <= WAKE; i++) begin
      tick();
      chk("R6 held low", 64'(actGates()), 64'(0));
    end
    tick();
    chk("R6 gates open", 64'(actGates()), 64'(expGates(1, 1)));

    // power-down with reference high
    refLevel = 1'b1;
    tick();
    pdReqN = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R4 ref held while high", 64'(actGates()), 64'(expGates(0, 1)));
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 wait ref", {62'b0, vcoEn, oscEn}, 64'd3);
      chk("R4 ref stays", 64'(refGate), 64'd1);
    end
    refLevel = 1'b0;
    tick();
    chk("R4 ref parked", 64'(refGate), 64'd0);
    chk("R3 off after ref", {62'b0, vcoEn, oscEn}, 64'd0);

    // re-request inside the start-up window
    pdReqN = 1'b1;
    tick(); tick(); tick();
    chk("R10 osc back", {62'b0, vcoEn, oscEn}, 64'd3);
    tick(); tick();
    pdReqN = 1'b0;
    tick(); tick();
    chk("R10 gates low", 64'(actGates()), 64'(0));
    tick();
    chk("R10 back off", {62'b0, vcoEn, oscEn}, 64'd0);
    chk("R10 gates low2", 64'(actGates()), 64'(0));
    pdReqN = 1'b1;
    for (int i = 0; i < WAKE + 3; i++) begin
      tick();
      chk("R10 no opening", 64'(actGates()), 64'(0));
    end
    tick();
    chk("R7 run again", 64'(actGates()), 64'(expGates(1, 1)));

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule